// File: doc/BRIEF.md
# Parallel-Indexed Physically-Tagged Cache Lookup

This block holds the tag side of a direct-mapped first-level data cache and decides hit or miss for each load. Only the untranslated part of the address, the byte offset within a page, enters the block. The set is chosen from offset bits above the line offset. The tag and valid arrays are therefore read in the same cycle in which an external TLB translates the page number. One cycle after the request, the TLB's answer arrives on its own inputs. The stored tag is then compared with the returned physical frame number, and the block gives a hit, a miss or a retry. A retry means the translation was missing or faulted and the load must be issued again once the TLB has been refilled.

A line fill writes a physical tag and one data word into a named set and marks that set valid. Because the set bits sit inside the page offset, every virtual alias of a physical line picks the same set. Elaboration fails if the parameters place set and line-offset bits outside the page offset.

Top module: `vipt_lookup`

## Requirements
- R1: After reset no set is valid: a lookup with a good translation reports rsp_valid=1, rsp_hit=0 and rsp_retry=0.
- R2: rsp_valid is 1 exactly one cycle after req_valid is 1 and is 0 otherwise, including throughout reset.
- R3: The set used is req_off[11:6]. A fill to set s is found by a lookup whose req_off[11:6] equals s, and by no other set.
- R4: With a good translation, a valid set whose stored tag differs from tlb_pfn gives a miss (hit=0, retry=0).
- R5: tlb_hit=0 in the response cycle gives rsp_retry=1 and rsp_hit=0, even when the stored tag matches.
- R6: tlb_fault=1 in the response cycle gives rsp_retry=1 and rsp_hit=0, even when the stored tag matches.
- R7: On a response that is not a retry, rsp_pa equals {tlb_pfn, req_off of the request}. On a retry or with no response it is 0.
- R8: On a hit, rsp_word is the word written by the most recent fill of that set. Otherwise it is 0.
- R9: Two virtual addresses with different page numbers and the same page offset that translate to the same frame both hit the line filled through either one.
- R10: A fill and a lookup to the same set at the same clock edge: the lookup sees the set as it was before the fill, and the next lookup sees the new contents.
- R11: A refill of a set replaces its tag: the old frame number then misses and the new one hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_off | input | PAGE_OFF_W | Untranslated page-offset bits of the load address |
| tlb_hit | input | 1 | TLB found a translation (response cycle) |
| tlb_fault | input | 1 | TLB reports a fault (response cycle) |
| tlb_pfn | input | PA_W-PAGE_OFF_W | Physical frame number from the TLB (response cycle) |
| fill_en | input | 1 | Line fill strobe |
| fill_set | input | SET_W | Set being filled |
| fill_pfn | input | PA_W-PAGE_OFF_W | Physical tag to store |
| fill_word | input | WORD_W | Data word to store |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Cache hit |
| rsp_retry | output | 1 | Translation missing or faulted; reissue after refill |
| rsp_pa | output | PA_W | Physical address of the load |
| rsp_word | output | WORD_W | Data word on a hit |

## Verification
The hardest case is a fill and a lookup on the same set at the same edge. The array is read in the cycle it is written, and the outcome must reflect the state before the write. The bench drives both strobes in one cycle on a set that has never been filled, so a wrong ordering shows up as a false hit. It then repeats the lookup alone to check that the fill took effect. The alias case is reached by building two virtual addresses that differ only in the page number, passing only their common offset to the block, and giving both the same frame on the TLB inputs.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    LKP_IDLE  = 2'd0,
    LKP_HIT   = 2'd1,
    LKP_MISS  = 2'd2,
    LKP_RETRY = 2'd3
  } lkp_outcome_e;
endpackage

// File: rtl/vipt_tag_store.sv
// Valid bits in flops (cleared on reset), tag and word arrays without reset.
// Read is synchronous and returns the contents before a same-edge fill.
module vipt_tag_store #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  localparam int SETS  = 1 << SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_word,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [WORD_W-1:0] rd_word
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [WORD_W-1:0] word_mem [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_set] <= 1'b1;
      if (rd_en) rd_vld <= vld_q[rd_set];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      word_mem[wr_set] <= wr_word;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_word <= word_mem[rd_set];
    end
  end
endmodule

// File: rtl/vipt_hit_eval.sv
// Combines the registered tag read with the TLB answer of the same cycle.
module vipt_hit_eval
  import vipt_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             pending,
  input  logic             line_vld,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             xl_hit,
  input  logic             xl_fault,
  input  logic [TAG_W-1:0] xl_pfn,
  output lkp_outcome_e     outcome,
  output logic             tag_eq
);
  logic xl_good;

  always_comb begin
    tag_eq  = line_vld && (line_tag == xl_pfn);
    xl_good = xl_hit && !xl_fault;
    if (!pending)      outcome = LKP_IDLE;
    else if (!xl_good) outcome = LKP_RETRY;
    else if (tag_eq)   outcome = LKP_HIT;
    else               outcome = LKP_MISS;
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 6,
  parameter int SET_W      = 6,
  parameter int PA_W       = 32,
  parameter int WORD_W     = 32,
  localparam int PFN_W     = PA_W - PAGE_OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [PAGE_OFF_W-1:0] req_off,
  input  logic                  tlb_hit,
  input  logic                  tlb_fault,
  input  logic [PFN_W-1:0]      tlb_pfn,
  input  logic                  fill_en,
  input  logic [SET_W-1:0]      fill_set,
  input  logic [PFN_W-1:0]      fill_pfn,
  input  logic [WORD_W-1:0]     fill_word,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_retry,
  output logic [PA_W-1:0]       rsp_pa,
  output logic [WORD_W-1:0]     rsp_word
);
  // Set and line-offset bits must stay inside the page offset, or aliases
  // of one physical line could occupy different sets.
  if (SET_W + LINE_OFF_W > PAGE_OFF_W) begin : g_alias_guard
    $error("set index plus line offset exceeds page offset width");
  end

  function automatic logic [SET_W-1:0] set_of(input logic [PAGE_OFF_W-1:0] off);
    return off[LINE_OFF_W +: SET_W];
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PFN_W-1:0] pfn,
                                                input logic [PAGE_OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  logic                  req_q;
  logic [PAGE_OFF_W-1:0] off_q;
  logic                  line_vld;
  logic [PFN_W-1:0]      line_tag;
  logic [WORD_W-1:0]     line_word;
  lkp_outcome_e          outcome;
  logic                  tag_eq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      off_q <= '0;
    end else begin
      req_q <= req_valid;
      if (req_valid) off_q <= req_off;
    end
  end

  vipt_tag_store #(
    .SET_W  (SET_W),
    .TAG_W  (PFN_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (req_valid),
    .rd_set  (set_of(req_off)),
    .wr_en   (fill_en),
    .wr_set  (fill_set),
    .wr_tag  (fill_pfn),
    .wr_word (fill_word),
    .rd_vld  (line_vld),
    .rd_tag  (line_tag),
    .rd_word (line_word)
  );

  vipt_hit_eval #(
    .TAG_W (PFN_W)
  ) u_eval (
    .pending  (req_q),
    .line_vld (line_vld),
    .line_tag (line_tag),
    .xl_hit   (tlb_hit),
    .xl_fault (tlb_fault),
    .xl_pfn   (tlb_pfn),
    .outcome  (outcome),
    .tag_eq   (tag_eq)
  );

  always_comb begin
    rsp_valid = req_q;
    rsp_hit   = (outcome == LKP_HIT);
    rsp_retry = (outcome == LKP_RETRY);
    rsp_pa    = (outcome == LKP_HIT || outcome == LKP_MISS) ? phys_addr(tlb_pfn, off_q) : '0;
    rsp_word  = (rsp_hit && tag_eq) ? line_word : '0;
  end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int PAGE_OFF_W = 12,
  parameter int PA_W       = 32,
  parameter int WORD_W     = 32,
  localparam int PFN_W     = PA_W - PAGE_OFF_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [PAGE_OFF_W-1:0] req_off,
  input logic                  tlb_hit,
  input logic                  tlb_fault,
  input logic [PFN_W-1:0]      tlb_pfn,
  input logic                  rsp_valid,
  input logic                  rsp_hit,
  input logic                  rsp_retry,
  input logic [PA_W-1:0]       rsp_pa,
  input logic [WORD_W-1:0]     rsp_word
);
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r5_r6_bad_xlate_retries: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (!tlb_hit || tlb_fault)) |-> (rsp_retry && !rsp_hit));

  a_r5_hit_retry_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_retry));

  a_r7_pa_formed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 (rsp_valid && !rsp_retry)) |-> rsp_pa == {tlb_pfn, $past(req_off)});

  a_r8_word_zero_off_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_word == '0);
endmodule

bind vipt_lookup vipt_lookup_chk #(
  .PAGE_OFF_W (PAGE_OFF_W),
  .PA_W       (PA_W),
  .WORD_W     (WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_off   (req_off),
  .tlb_hit   (tlb_hit),
  .tlb_fault (tlb_fault),
  .tlb_pfn   (tlb_pfn),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_retry (rsp_retry),
  .rsp_pa    (rsp_pa),
  .rsp_word  (rsp_word)
);

// File: tb/tb_vipt_lookup.sv
`timescale 1ns/1ps
module tb_vipt_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_off = '0;
  logic        tlb_hit = 1'b0;
  logic        tlb_fault = 1'b0;
  logic [19:0] tlb_pfn = '0;
  logic        fill_en = 1'b0;
  logic [5:0]  fill_set = '0;
  logic [19:0] fill_pfn = '0;
  logic [31:0] fill_word = '0;
  logic        rsp_valid, rsp_hit, rsp_retry;
  logic [31:0] rsp_pa, rsp_word;

  int n_chk = 0;
  int n_err = 0;

  logic        g_valid, g_hit, g_retry;
  logic [31:0] g_pa, g_word;

  always #2 clk = ~clk;

  vipt_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_off(req_off),
    .tlb_hit(tlb_hit), .tlb_fault(tlb_fault), .tlb_pfn(tlb_pfn),
    .fill_en(fill_en), .fill_set(fill_set), .fill_pfn(fill_pfn), .fill_word(fill_word),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retry(rsp_retry),
    .rsp_pa(rsp_pa), .rsp_word(rsp_word)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_off(input logic [5:0] s, input logic [5:0] lo);
    return {s, lo};
  endfunction

  task automatic do_fill(input logic [5:0] s, input logic [19:0] pfn, input logic [31:0] w);
    @(negedge clk);
    fill_en = 1'b1; fill_set = s; fill_pfn = pfn; fill_word = w;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Request at one edge, TLB answer and sampling in the following cycle.
  task automatic do_lookup(input logic [11:0] off, input logic th, input logic tf,
                           input logic [19:0] pfn, input logic with_fill,
                           input logic [19:0] fpfn, input logic [31:0] fw);
    @(negedge clk);
    req_valid = 1'b1; req_off = off;
    if (with_fill) begin
      fill_en = 1'b1; fill_set = off[11:6]; fill_pfn = fpfn; fill_word = fw;
    end
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    tlb_hit = th; tlb_fault = tf; tlb_pfn = pfn;
    #1;
    g_valid = rsp_valid; g_hit = rsp_hit; g_retry = rsp_retry;
    g_pa = rsp_pa; g_word = rsp_word;
  endtask

  task automatic t_reset;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no response in reset", rsp_valid, 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    do_lookup(mk_off(6'd5, 6'd0), 1, 0, 20'h12345, 0, 0, 0);
    chk("R1 valid after reset", g_valid, 1);
    chk("R1 no hit after reset", g_hit, 0);
    chk("R1 no retry after reset", g_retry, 0);
  endtask

  task automatic t_idle;
    @(negedge clk); @(negedge clk);
    chk("R2 idle rsp_valid", rsp_valid, 0);
    chk("R2 idle rsp_hit", rsp_hit, 0);
  endtask

  task automatic t_fill_hit;
    do_fill(6'd3, 20'hABCDE, 32'h1111_2222);
    do_lookup(mk_off(6'd3, 6'h14), 1, 0, 20'hABCDE, 0, 0, 0);
    chk("R3 hit filled set", g_hit, 1);
    chk("R8 word on hit", g_word, 32'h1111_2222);
    chk("R7 pa on hit", g_pa, {20'hABCDE, mk_off(6'd3, 6'h14)});
    do_lookup(mk_off(6'd4, 6'h14), 1, 0, 20'hABCDE, 0, 0, 0);
    chk("R3 other set misses", g_hit, 0);
    chk("R8 word zero on miss", g_word, 0);
  endtask

  task automatic t_tag_mismatch;
    do_lookup(mk_off(6'd3, 6'h3F), 1, 0, 20'hABCDF, 0, 0, 0);
    chk("R4 mismatch no hit", g_hit, 0);
    chk("R4 mismatch no retry", g_retry, 0);
    chk("R7 pa on miss", g_pa, {20'hABCDF, mk_off(6'd3, 6'h3F)});
  endtask

  task automatic t_tlb_bad;
    do_lookup(mk_off(6'd3, 6'h00), 0, 0, 20'hABCDE, 0, 0, 0);
    chk("R5 tlb miss retry", g_retry, 1);
    chk("R5 tlb miss no hit", g_hit, 0);
    chk("R7 pa zero on retry", g_pa, 0);
    do_lookup(mk_off(6'd3, 6'h00), 1, 1, 20'hABCDE, 0, 0, 0);
    chk("R6 fault retry", g_retry, 1);
    chk("R6 fault no hit", g_hit, 0);
    chk("R8 word zero on fault", g_word, 0);
  endtask

  task automatic t_synonym;
    logic [31:0] va_a, va_b;
    va_a = 32'h0001_2000 | 32'h0000_0A48;
    va_b = 32'h7777_7000 | 32'h0000_0A48;
    do_fill(va_a[11:6], 20'h0BEEF, 32'hCAFE_0001);
    do_lookup(va_a[11:0], 1, 0, 20'h0BEEF, 0, 0, 0);
    chk("R9 first alias hits", g_hit, 1);
    do_lookup(va_b[11:0], 1, 0, 20'h0BEEF, 0, 0, 0);
    chk("R9 second alias hits", g_hit, 1);
    chk("R9 second alias word", g_word, 32'hCAFE_0001);
  endtask

  task automatic t_same_edge;
    do_lookup(mk_off(6'd9, 6'd4), 1, 0, 20'h33333, 1, 20'h33333, 32'h0000_9999);
    chk("R10 same-edge sees old state", g_hit, 0);
    do_lookup(mk_off(6'd9, 6'd4), 1, 0, 20'h33333, 0, 0, 0);
    chk("R10 next lookup hits", g_hit, 1);
    chk("R10 next lookup word", g_word, 32'h0000_9999);
  endtask

  task automatic t_overwrite;
    do_fill(6'd3, 20'h44444, 32'h0000_0005);
    do_lookup(mk_off(6'd3, 6'd0), 1, 0, 20'hABCDE, 0, 0, 0);
    chk("R11 old tag misses", g_hit, 0);
    do_lookup(mk_off(6'd3, 6'd0), 1, 0, 20'h44444, 0, 0, 0);
    chk("R11 new tag hits", g_hit, 1);
    chk("R11 new word", g_word, 32'h0000_0005);
  endtask

  task automatic t_all_sets;
    for (int s = 0; s < 64; s++) do_fill(6'(s), 20'(32'h100 + s), 32'(32'hD000 + s));
    for (int s = 0; s < 64; s++) begin
      do_lookup(mk_off(6'(s), 6'(s)), 1, 0, 20'(32'h100 + s), 0, 0, 0);
      chk("R3 sweep hit", g_hit, 1);
      chk("R8 sweep word", g_word, 32'(32'hD000 + s));
    end
    do_lookup(mk_off(6'd10, 6'd0), 1, 0, 20'h10B, 0, 0, 0);
    chk("R3 neighbour tag misses", g_hit, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_fill_hit();
    t_tag_mismatch();
    t_tlb_bad();
    t_synonym();
    t_same_edge();
    t_overwrite();
    t_all_sets();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule